// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This peripheral counts ticks from one of two clock-enable inputs in a 16-bit up-counter. It works either as a watchdog or as a periodic interval timer. As a watchdog, it requests a system reset when software fails to clear the counter in time. As an interval timer, it raises an interrupt flag at a fixed tick period. The expiry period is taken from one of four counter taps.

Software controls the block through a single 16-bit control register. A write takes effect only when its upper byte carries the key value 0x5A. A write with any other upper byte leaves the settings alone and requests a system reset. A read returns the fixed byte 0x69 in the upper half and the current settings in the lower half.

Control byte layout:
- bit 7 is hold: 1 freezes the counter.
- bit 4 is mode: 0 selects watchdog, 1 selects interval.
- bit 3 is counter clear.
- bit 2 is source: 0 selects `tick_fast`, 1 selects `tick_slow`.
- bits 1:0 are the period field.
- bits 6:5 are stored and read back.

Top module: `guard_timer`

## Requirements
- R1: The counter advances by one on each clock where the selected tick input is high. Source bit 2 = 0 selects `tick_fast` and source bit 2 = 1 selects `tick_slow`. Ticks on the unselected input have no effect.
- R2: A write whose upper byte is not 0x5A changes no setting. It drives `sys_rst_req` high in the cycle after the write edge.
- R3: `reg_rdata` always reads {0x69, settings}. The clear bit (bit 3) always reads 0.
- R4: The period field sets the expiry count: 00 gives 32768 ticks, 01 gives 8192, 10 gives 512 and 11 gives 64. Ticks are counted from the last counter clear.
- R5: A keyed write with bit 3 set resets the counter to zero. This takes priority over a tick in the same cycle.
- R6: In watchdog mode, expiry drives `sys_rst_req` high for exactly one cycle. A clear written before expiry postpones the reset by a full period.
- R7: In interval mode, expiry sets `irq_flag` and never requests a reset.
- R8: `irq_req` is high only while `irq_flag`, `irq_en` and `gie` are all high.
- R9: `irq_ack` clears the flag in interval mode and is ignored in watchdog mode. `flag_clr` clears the flag in either mode.
- R10: While hold (bit 7) is set, the counter does not advance.
- R11: After reset the block is in watchdog mode with the counter at zero, hold off, the fast source and the 32768 period selected. Both requests and the flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_fast | input | 1 | Count enable from the fast source |
| tick_slow | input | 1 | Count enable from the slow source |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 16 | Write data, key in upper byte |
| reg_rdata | output | 16 | Control register read value |
| irq_en | input | 1 | Local interrupt enable |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge strobe |
| flag_clr | input | 1 | Software flag clear strobe |
| irq_flag | output | 1 | Interval expiry flag |
| irq_req | output | 1 | Interrupt request |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
Each of the four period codes is run with an unbroken tick stream. The flag is checked one tick before the expected count and at it, which separates both the tap choice and off-by-one errors. Expiry is also tried in the following situations, each of which shows whether the right enable and the right mode gate the count:
- ticks only on the unselected source,
- ticks while hold is set,
- a watchdog kick in mid-period.

The bench also covers the gating of acknowledge and enables, a bad-key write and the register readback.

// File: rtl/guard_timer.sv
module guard_timer #(
  parameter int        W      = 16,
  parameter logic [7:0] KEY   = 8'h5A,
  parameter logic [7:0] RD_ID = 8'h69
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_fast,
  input  logic        tick_slow,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        irq_en,
  input  logic        gie,
  input  logic        irq_ack,
  input  logic        flag_clr,
  output logic        irq_flag,
  output logic        irq_req,
  output logic        sys_rst_req
);
  logic [7:0]   ctrl;
  logic [W-1:0] cnt;
  logic [W-1:0] cnt_nx;
  logic [W-1:0] mask;
  logic         hold, mode_ivl, src_slow;
  logic [1:0]   ivl;
  logic         key_ok, bad_wr, kick, tick, run, fire, ivl_fire;

  assign hold     = ctrl[7];
  assign mode_ivl = ctrl[4];
  assign src_slow = ctrl[2];
  assign ivl      = ctrl[1:0];

  assign key_ok = reg_wdata[15:8] == KEY;
  assign bad_wr = reg_wr & ~key_ok;
  assign kick   = reg_wr & key_ok & reg_wdata[3];

  assign tick   = src_slow ? tick_slow : tick_fast;
  assign run    = tick & ~hold;
  assign cnt_nx = cnt + 1'b1;

  always_comb begin
    case (ivl)
      2'b00:   mask = W'((1 << 15) - 1);
      2'b01:   mask = W'((1 << 13) - 1);
      2'b10:   mask = W'((1 << 9) - 1);
      default: mask = W'((1 << 6) - 1);
    endcase
  end

  assign fire     = run & ~kick & ((cnt_nx & mask) == '0);
  assign ivl_fire = fire & mode_ivl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= 8'h00;
    end else if (reg_wr && key_ok) begin
      ctrl <= {reg_wdata[7:4], 1'b0, reg_wdata[2:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (kick)   cnt <= '0;
    else if (run)    cnt <= cnt_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          irq_flag <= 1'b0;
    else if (ivl_fire)                   irq_flag <= 1'b1;
    else if (flag_clr)                   irq_flag <= 1'b0;
    else if (irq_ack && mode_ivl)        irq_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sys_rst_req <= 1'b0;
    else        sys_rst_req <= bad_wr | (fire & ~mode_ivl);
  end

  assign irq_req   = irq_flag & irq_en & gie;
  assign reg_rdata = {RD_ID, ctrl};
endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk #(
  parameter int        W   = 16,
  parameter logic [7:0] KEY = 8'h5A
) (
  input logic         clk,
  input logic         rst_n,
  input logic         reg_wr,
  input logic [15:0]  reg_wdata,
  input logic [15:0]  reg_rdata,
  input logic         gie,
  input logic         flag_clr,
  input logic         irq_flag,
  input logic         irq_req,
  input logic         sys_rst_req,
  input logic         c_hold,
  input logic         c_set,
  input logic [W-1:0] c_cnt
);
  // R2
  bad_key_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[15:8] != KEY) |=> sys_rst_req);
  // R2
  bad_key_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[15:8] != KEY) |=> $stable(reg_rdata[7:0]));
  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[15:8] == KEY && reg_wdata[3]) |=> c_cnt == '0);
  // R10
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_hold && !reg_wr) |=> $stable(c_cnt));
  // R8
  gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq_req);
  // R9
  sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !c_set) |=> !irq_flag);
endmodule

bind guard_timer guard_timer_chk #(.W(W), .KEY(KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .gie(gie), .flag_clr(flag_clr), .irq_flag(irq_flag),
  .irq_req(irq_req), .sys_rst_req(sys_rst_req), .c_hold(hold),
  .c_set(ivl_fire), .c_cnt(cnt)
);

// File: tb/sim_guard_timer.sv
module sim_guard_timer;
  logic clk = 0, rst_n = 0;
  logic tick_fast = 0, tick_slow = 0, reg_wr = 0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic irq_en = 0, gie = 0, irq_ack = 0, flag_clr = 0;
  logic irq_flag, irq_req, sys_rst_req;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  guard_timer u0 (.*);

  localparam int NV = 4;
  localparam logic [15:0] VCTRL [NV] = '{16'h5A18, 16'h5A19, 16'h5A1A, 16'h5A1B};
  localparam int          VCNT  [NV] = '{32768, 8192, 512, 64};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] v);
    @(negedge clk); reg_wr = 1; reg_wdata = v;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog timeout actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    edges(3); rst_n = 1; edges(1);
    // R11 R3 reset state
    chk(reg_rdata == 16'h6900, "R11", reg_rdata, 16'h6900);
    chk(!sys_rst_req && !irq_flag && !irq_req, "R11", {sys_rst_req, irq_flag, irq_req}, 0);

    // R4 R7 period table
    for (int i = 0; i < NV; i++) begin
      tick_fast = 0;
      pulse_clr();
      wr(VCTRL[i]);
      tick_fast = 1;
      edges(VCNT[i] - 1);
      chk(!irq_flag, "R4", irq_flag, 0);
      edges(1);
      chk(irq_flag, "R4", irq_flag, 1);
      chk(!sys_rst_req, "R7", sys_rst_req, 0);
    end
    tick_fast = 0;

    // R3 readback, clear bit reads 0
    wr(16'h5A1F);
    chk(reg_rdata == 16'h6917, "R3", reg_rdata, 16'h6917);

    // R2 bad key
    wr(16'h1234);
    chk(sys_rst_req, "R2", sys_rst_req, 1);
    chk(reg_rdata == 16'h6917, "R2", reg_rdata, 16'h6917);
    edges(1);
    chk(!sys_rst_req, "R2", sys_rst_req, 0);

    // R8 enable gating (flag still set)
    pulse_clr();
    wr(16'h5A1B); tick_fast = 1; edges(64); tick_fast = 0;
    chk(irq_flag, "R7", irq_flag, 1);
    irq_en = 0; gie = 1; edges(1);
    chk(!irq_req, "R8", irq_req, 0);
    irq_en = 1; gie = 0; edges(1);
    chk(!irq_req, "R8", irq_req, 0);
    gie = 1; edges(1);
    chk(irq_req, "R8", irq_req, 1);

    // R9 ack in interval mode
    @(negedge clk); irq_ack = 1; @(negedge clk); irq_ack = 0;
    chk(!irq_flag, "R9", irq_flag, 0);

    // R9 ack ignored in watchdog mode
    wr(16'h5A1B); tick_fast = 1; edges(64); tick_fast = 0;
    wr(16'h5A03);
    @(negedge clk); irq_ack = 1; @(negedge clk); irq_ack = 0;
    chk(irq_flag, "R9", irq_flag, 1);
    pulse_clr();
    chk(!irq_flag, "R9", irq_flag, 0);

    // R6 R5 watchdog kick and expiry
    wr(16'h5A0B); tick_fast = 1;
    edges(63); tick_fast = 0;
    chk(!sys_rst_req, "R6", sys_rst_req, 0);
    wr(16'h5A0B); tick_fast = 1;
    edges(63);
    chk(!sys_rst_req, "R5", sys_rst_req, 0);
    edges(1);
    chk(sys_rst_req, "R6", sys_rst_req, 1);
    edges(1);
    chk(!sys_rst_req, "R6", sys_rst_req, 0);
    tick_fast = 0;

    // R10 hold
    wr(16'h5A9B); tick_fast = 1; edges(100); tick_fast = 0;
    chk(!irq_flag, "R10", irq_flag, 0);
    wr(16'h5A13); tick_fast = 1;
    edges(63);
    chk(!irq_flag, "R10", irq_flag, 0);
    edges(1);
    chk(irq_flag, "R10", irq_flag, 1);
    tick_fast = 0;

    // R1 slow source
    pulse_clr();
    wr(16'h5A1F); tick_fast = 1; edges(100); tick_fast = 0;
    chk(!irq_flag, "R1", irq_flag, 0);
    tick_slow = 1; edges(63);
    chk(!irq_flag, "R1", irq_flag, 0);
    edges(1);
    chk(irq_flag, "R1", irq_flag, 1);
    tick_slow = 0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule